// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a data word left logically, right logically or right arithmetically by a count taken modulo 64. A log-depth barrel array produces the result. A separate selector finds the bit that left the word last, and that bit becomes the carry. The carry rules cover the whole reduced range of counts. A zero count passes the data through unchanged and keeps the incoming carry. A count equal to the word width has its own carry rule. A count beyond the word width clears the carry for logical shifts, and for arithmetic shifts it gives the sign bit as the carry.

The datapath is purely combinational. The result and the condition flags are captured in one output register stage, and only in cycles where the enable input is high. The flags are carry, extend, negative, zero and overflow. Extend always copies the new carry. Negative is the result's top bit. Zero reports an all-zero result. Overflow is always cleared. An execution pipeline uses the block as its shift unit. It feeds the previous carry flag back into `carry_in`, so that a zero-count shift leaves carry as it was.

Top module: `barrel_shift_cc`

## Requirements
- R1: Only the low 6 bits of the 8-bit `count` input set the shift amount (the count is reduced modulo 64). The upper bits have no effect on any output.
- R2: When the reduced count is 0, the result equals `data_in`, and carry takes the value of `carry_in`.
- R3: Left logical shift by n in 1..31 gives `data_in << n`, with carry equal to input bit 32-n.
- R4: Left logical shift by exactly 32 gives a zero result, with carry equal to input bit 0. A left shift by 33..63 gives a zero result with carry 0.
- R5: Right logical shift by n in 1..31 zero-fills from the top, with carry equal to input bit n-1.
- R6: Right logical shift by exactly 32 gives a zero result, with carry equal to input bit 31. A right logical shift by 33..63 gives a zero result with carry 0.
- R7: Right arithmetic shift by n in 1..31 fills from the top with copies of bit 31, with carry equal to input bit n-1. For a count of 32..63, every result bit and the carry equal input bit 31.
- R8: After every captured operation, `extend` equals `carry`, including the zero-count case.
- R9: `neg` is result bit 31. `zero` is 1 exactly when the result is all zeros. `ovf` is always 0.
- R10: The `op` encoding is: 2'b00 is left logical, 2'b01 is right logical, and both 2'b10 and 2'b11 are right arithmetic.
- R11: All outputs update on the rising clock edge in which `en` is 1. With `en` at 0, they hold their previous values.
- R12: A synchronous active-high `rst` clears every output to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable for the output register |
| data_in | input | 32 | Word to shift |
| count | input | 8 | Shift amount; the low 6 bits are used |
| op | input | 2 | Shift kind (see R10) |
| carry_in | input | 1 | Previous carry flag, kept on zero count |
| result | output | 32 | Registered shifted word |
| carry | output | 1 | Registered carry flag |
| extend | output | 1 | Registered extend flag (copy of carry) |
| neg | output | 1 | Registered negative flag |
| zero | output | 1 | Registered zero flag |
| ovf | output | 1 | Registered overflow flag (always 0) |

## Verification
In one cycle, the modulo reduction of the count and the width-boundary carry rule can act together. A count of 96 or 160 reduces to exactly 32, and a count of 64 or 128 reduces to zero and must take the pass-through path that keeps the carry. The bench drives these aliased counts with data whose low and high bits differ, so that each carry rule gives a different answer. It compares the outputs against a model that shifts a 64-bit concatenation. A second overlap is capture-enable against the carry-keep path. The bench changes `carry_in` and the data while `en` is low, checks that nothing moves, and then captures a zero-count shift.

// File: rtl/shift_pkg.sv
package shift_pkg;

  typedef enum logic [1:0] {
    SH_LSL     = 2'b00,
    SH_LSR     = 2'b01,
    SH_ASR     = 2'b10,
    SH_ASR_ALT = 2'b11
  } shift_op_e;

  function automatic logic op_is_left(input logic [1:0] op);
    return (op == SH_LSL);
  endfunction

  function automatic logic op_is_arith(input logic [1:0] op);
    return op[1];
  endfunction

endpackage

// File: rtl/shift_array.sv
module shift_array
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int MOD_W = 6
) (
  input  logic [WIDTH-1:0] data,
  input  logic [MOD_W-1:0] amt,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] res
);
  localparam int STG = $clog2(WIDTH);

  logic             left;
  logic             fill;
  logic             over;
  logic [(STG+1)*WIDTH-1:0] chain;

  assign left  = op_is_left(op);
  assign fill  = op_is_arith(op) & data[WIDTH-1];
  assign over  = (amt > MOD_W'(WIDTH - 1));
  assign chain[WIDTH-1:0] = data;

  for (genvar k = 0; k < STG; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] shl;
    logic [WIDTH-1:0] shr;
    assign cur = chain[k*WIDTH +: WIDTH];
    assign shl = {cur[WIDTH-1-D:0], {D{1'b0}}};
    assign shr = {{D{fill}}, cur[WIDTH-1:D]};
    assign chain[(k+1)*WIDTH +: WIDTH] = !amt[k] ? cur : (left ? shl : shr);
  end

  assign res = over ? {WIDTH{fill}} : chain[STG*WIDTH +: WIDTH];

endmodule

// File: rtl/shift_carry.sv
module shift_carry
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int MOD_W = 6
) (
  input  logic [WIDTH-1:0] data,
  input  logic [MOD_W-1:0] amt,
  input  logic [1:0]       op,
  input  logic             carry_in,
  output logic             cy
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [MOD_W-1:0] left_pos;
  logic [MOD_W-1:0] right_pos;

  assign left_pos  = MOD_W'(WIDTH) - amt;
  assign right_pos = amt - MOD_W'(1);

  always_comb begin
    if (amt == '0) begin
      cy = carry_in;
    end else if (amt < MOD_W'(WIDTH)) begin
      cy = op_is_left(op) ? data[left_pos[IDX_W-1:0]] : data[right_pos[IDX_W-1:0]];
    end else if (amt == MOD_W'(WIDTH)) begin
      cy = op_is_left(op) ? data[0] : data[WIDTH-1];
    end else begin
      cy = op_is_arith(op) & data[WIDTH-1];
    end
  end

endmodule

// File: rtl/shift_outreg.sv
module shift_outreg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_cy,
  output logic [WIDTH-1:0] q_res,
  output logic             q_cy,
  output logic             q_ext,
  output logic             q_neg,
  output logic             q_zero,
  output logic             q_ovf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_res  <= '0;
      q_cy   <= 1'b0;
      q_ext  <= 1'b0;
      q_neg  <= 1'b0;
      q_zero <= 1'b0;
      q_ovf  <= 1'b0;
    end else if (en) begin
      q_res  <= d_res;
      q_cy   <= d_cy;
      q_ext  <= d_cy;
      q_neg  <= d_res[WIDTH-1];
      q_zero <= ~|d_res;
      q_ovf  <= 1'b0;
    end
  end

endmodule

// File: rtl/barrel_shift_cc.sv
module barrel_shift_cc
  import shift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8,
  parameter int MOD_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] data_in,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       op,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry,
  output logic             extend,
  output logic             neg,
  output logic             zero,
  output logic             ovf
);
  logic [MOD_W-1:0] amt;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cy;

  assign amt = count[MOD_W-1:0];

  shift_array #(.WIDTH(WIDTH), .MOD_W(MOD_W)) array_i (
    .data (data_in),
    .amt  (amt),
    .op   (op),
    .res  (sh_res)
  );

  shift_carry #(.WIDTH(WIDTH), .MOD_W(MOD_W)) carry_i (
    .data     (data_in),
    .amt      (amt),
    .op       (op),
    .carry_in (carry_in),
    .cy       (sh_cy)
  );

  shift_outreg #(.WIDTH(WIDTH)) oreg_i (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .d_res  (sh_res),
    .d_cy   (sh_cy),
    .q_res  (result),
    .q_cy   (carry),
    .q_ext  (extend),
    .q_neg  (neg),
    .q_zero (zero),
    .q_ovf  (ovf)
  );

endmodule

// File: rtl/barrel_shift_cc_chk.sv
module barrel_shift_cc_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 8,
  parameter int MOD_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [WIDTH-1:0] data_in,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       op,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry,
  input logic             extend,
  input logic             neg,
  input logic             zero,
  input logic             ovf
);
  logic [MOD_W-1:0] amt;
  assign amt = count[MOD_W-1:0];

  // R12
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && !carry && !extend && !neg && !zero && !ovf));

  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result) && $stable(carry) && $stable(extend) && $stable(zero)));

  // R2
  a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
    (en && amt == '0) |=> (result == $past(data_in) && carry == $past(carry_in)));

  // R4
  a_r4_lsl_beyond: assert property (@(posedge clk) disable iff (rst)
    (en && op == 2'b00 && amt > MOD_W'(WIDTH)) |=> (result == '0 && !carry));

  // R7
  a_r7_asr_wide: assert property (@(posedge clk) disable iff (rst)
    (en && op[1] && amt >= MOD_W'(WIDTH)) |=>
      (result == {WIDTH{$past(data_in[WIDTH-1])}} && carry == $past(data_in[WIDTH-1])));

  // R8
  a_r8_ext_follows: assert property (@(posedge clk) disable iff (rst)
    en |=> (extend == carry));

  // R9
  a_r9_flags: assert property (@(posedge clk) disable iff (rst)
    en |=> (zero == (result == '0) && neg == result[WIDTH-1] && !ovf));

endmodule

bind barrel_shift_cc barrel_shift_cc_chk #(
  .WIDTH(WIDTH), .CNT_W(CNT_W), .MOD_W(MOD_W)
) chk_i (.*);

// File: tb/barrel_shift_cc_tb_top.sv
`timescale 1ns/1ps
module barrel_shift_cc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] data_in = '0;
  logic [7:0]  count = '0;
  logic [1:0]  op = '0;
  logic        carry_in = 1'b0;
  logic [31:0] result;
  logic        carry, extend, neg, zero, ovf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [36:0] last_exp = '0;

  always #2.5 clk = ~clk;

  barrel_shift_cc dut_i (
    .clk(clk), .rst(rst), .en(en), .data_in(data_in), .count(count),
    .op(op), .carry_in(carry_in), .result(result), .carry(carry),
    .extend(extend), .neg(neg), .zero(zero), .ovf(ovf)
  );

  // {result, carry, extend, neg, zero, ovf}
  function automatic logic [36:0] model(input logic [31:0] d, input logic [7:0] c,
                                        input logic [1:0] o, input logic cin);
    logic [5:0]  m;
    logic [63:0] w;
    logic [31:0] r;
    logic        cy;
    m = c[5:0];
    if (m == 6'd0) begin
      r = d; cy = cin;
    end else if (o == 2'b00) begin
      w = {32'b0, d} << m; r = w[31:0]; cy = w[32];
    end else if (o == 2'b01) begin
      w = {d, 32'b0} >> m; r = w[63:32]; cy = w[31];
    end else begin
      w = $signed({d, 32'b0}) >>> m; r = w[63:32]; cy = w[31];
    end
    return {r, cy, cy, r[31], (r == 32'd0), 1'b0};
  endfunction

  function automatic logic [36:0] observed();
    return {result, carry, extend, neg, zero, ovf};
  endfunction

  task automatic check(input string req, input logic [36:0] exp);
    logic [36:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual res=%h c=%b x=%b n=%b z=%b v=%b expected res=%h c=%b x=%b n=%b z=%b v=%b",
               req, act[36:5], act[4], act[3], act[2], act[1], act[0],
               exp[36:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic run(input string req, input logic [31:0] d, input logic [7:0] c,
                     input logic [1:0] o, input logic cin);
    @(negedge clk);
    en = 1'b1; data_in = d; count = c; op = o; carry_in = cin;
    @(negedge clk);
    en = 1'b0;
    last_exp = model(d, c, o, cin);
    check(req, last_exp);
  endtask

  task automatic t_reset();
    check("R12 reset", 37'd0);
  endtask

  task automatic t_zero_count();
    run("R2 zero count keeps carry=1", 32'hDEAD_BEEF, 8'd0, 2'b00, 1'b1);
    run("R2 zero count keeps carry=0 (R8)", 32'h8000_0001, 8'd0, 2'b10, 1'b0);
  endtask

  task automatic t_lsl_mid();
    run("R3 lsl 1", 32'h8000_0001, 8'd1, 2'b00, 1'b0);
    run("R3 lsl 4", 32'h1234_5678, 8'd4, 2'b00, 1'b1);
    run("R3 lsl 31", 32'h0000_0003, 8'd31, 2'b00, 1'b0);
  endtask

  task automatic t_lsl_edge();
    run("R4 lsl 32 carry=bit0", 32'h0000_0001, 8'd32, 2'b00, 1'b0);
    run("R4 lsl 32 carry=0", 32'hFFFF_FFFE, 8'd32, 2'b00, 1'b1);
    run("R4 lsl 33", 32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1);
    run("R4 lsl 63", 32'hFFFF_FFFF, 8'd63, 2'b00, 1'b1);
  endtask

  task automatic t_lsr();
    run("R5 lsr 1", 32'h0000_0003, 8'd1, 2'b01, 1'b0);
    run("R5 lsr 17", 32'hF0F0_0000, 8'd17, 2'b01, 1'b1);
    run("R5 lsr 31", 32'h8000_0000, 8'd31, 2'b01, 1'b0);
    run("R6 lsr 32", 32'h8000_0000, 8'd32, 2'b01, 1'b0);
    run("R6 lsr 40", 32'hFFFF_FFFF, 8'd40, 2'b01, 1'b1);
  endtask

  task automatic t_asr();
    run("R7 asr 4 neg", 32'h8000_0018, 8'd4, 2'b10, 1'b0);
    run("R7 asr 3 pos", 32'h4000_0004, 8'd3, 2'b10, 1'b1);
    run("R7 asr 32 neg", 32'h8000_0000, 8'd32, 2'b10, 1'b0);
    run("R7 asr 50 pos", 32'h7FFF_FFFF, 8'd50, 2'b10, 1'b1);
    run("R7 asr 63 neg", 32'hC000_0000, 8'd63, 2'b10, 1'b0);
  endtask

  task automatic t_op_alias();
    run("R10 op 11 acts as asr", 32'h8000_0010, 8'd5, 2'b11, 1'b0);
    run("R10 op 11 wide", 32'h9000_0000, 8'd33, 2'b11, 1'b0);
  endtask

  task automatic t_modulo();
    run("R1 count 65 -> 1", 32'h8000_0001, 8'd65, 2'b00, 1'b0);
    run("R1 count 64 -> 0", 32'h0000_5A5A, 8'd64, 2'b01, 1'b1);
    run("R1 count 96 -> 32", 32'h0000_0001, 8'd96, 2'b00, 1'b0);
    run("R1 count 160 -> 32", 32'h8000_0000, 8'd160, 2'b01, 1'b0);
    run("R1 count 255 -> 63", 32'h8000_0000, 8'd255, 2'b10, 1'b0);
  endtask

  task automatic t_flags();
    run("R9 zero result", 32'h0000_0000, 8'd3, 2'b01, 1'b1);
    run("R9 neg result", 32'h4000_0000, 8'd1, 2'b00, 1'b0);
  endtask

  task automatic t_hold();
    run("R11 capture", 32'h0F0F_0F0F, 8'd2, 2'b01, 1'b1);
    @(negedge clk);
    en = 1'b0; data_in = 32'hFFFF_FFFF; count = 8'd0; op = 2'b10; carry_in = 1'b0;
    @(negedge clk);
    check("R11 hold while en low", last_exp);
    @(negedge clk);
    check("R11 hold second cycle", last_exp);
    run("R11 capture after hold (R2)", 32'h1111_0000, 8'd0, 2'b00, 1'b1);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset mid run", 37'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_count();
    t_lsl_mid();
    t_lsl_edge();
    t_lsr();
    t_asr();
    t_op_alias();
    t_modulo();
    t_flags();
    t_hold();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule